// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer-Redirected Location

This block is the data store of a small accumulator-based controller core. It presents one byte-wide port: an address, a write strobe with write data, and a read value that follows the address combinationally. A second strobe applies a single-bit set or clear to the addressed byte, selected by a 3-bit bit index.

The low part of the address space holds special registers. An 8-bit pointer register sits at 01H and the accumulator at 05H. Location 00H has no storage of its own. Any access to it is forwarded to the address the pointer holds, and a pointer of 00H turns that access into a zero read or an ignored write. Addresses 20H through 7FH are general-purpose RAM. All other addresses are unimplemented: they read 00H and drop writes.

Top module: `dmem_core`

## Requirements
- R1: Each address from 20H to 7FH stores the byte written to it on the rising clock edge when `wr_en` is high, and `rd_data` shows it combinationally from `addr`.
- R2: Address 01H is the pointer register; it is written and read back like any other location.
- R3: Address 05H is the accumulator; it is written and read back like any other location.
- R4: A read or write at address 00H acts on the address held in the pointer register. This includes 01H and 05H.
- R5: When the pointer holds 00H, a read at address 00H returns 00H.
- R6: When the pointer holds 00H, a write at address 00H changes no storage.
- R7: Addresses 02H–04H, 06H–1FH and 80H–FFH read 00H, and writes to them change no storage.
- R8: With `bit_en` high, the bit at position `bit_idx` (0 is the LSB) of the addressed byte becomes `bit_val` (1 sets, 0 clears) on the next rising edge. The other seven bits are kept.
- R9: A bit operation at address 00H follows the same pointer redirect as a byte write; with a pointer of 00H it changes nothing.
- R10: When `wr_en` and `bit_en` are both high, the byte write takes effect and the bit operation is ignored.
- R11: A rising edge with `rst` high clears the pointer and the accumulator to 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Direct address |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| bit_en | input | 1 | Bit set/clear strobe |
| bit_idx | input | 3 | Bit position for the bit operation |
| bit_val | input | 1 | Value written to the selected bit |
| rd_data | output | 8 | Combinational read value |

## Verification
Assertions are checked on every cycle. They cover the zero read for a pointer of 00H, the zero read of unimplemented addresses, the blocked write through a pointer of 00H, accumulator byte and bit updates, and the reset clear. The directed scenarios cover the rest: the RAM range end to end, the redirect landing on RAM and on special registers, bit operations that reach RAM through the pointer, and the priority between a byte write and a bit operation issued together.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_PTR  = 2'd1,
        RG_ACC  = 2'd2,
        RG_GPR  = 2'd3
    } region_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            IW       = 7,
    parameter logic [AW-1:0] IND_ADDR = 8'h00,
    parameter logic [AW-1:0] PTR_ADDR = 8'h01,
    parameter logic [AW-1:0] ACC_ADDR = 8'h05,
    parameter logic [AW-1:0] GPR_BASE = 8'h20,
    parameter logic [AW-1:0] GPR_TOP  = 8'h7F
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] eff_addr,
    output region_e       region,
    output logic [IW-1:0] gpr_idx
);
    logic [AW-1:0] gpr_off;

    always_comb begin
        eff_addr = (addr == IND_ADDR) ? ptr : addr;
        gpr_off  = eff_addr - GPR_BASE;
        gpr_idx  = gpr_off[IW-1:0];
        if (eff_addr == PTR_ADDR)
            region = RG_PTR;
        else if (eff_addr == ACC_ADDR)
            region = RG_ACC;
        else if (eff_addr >= GPR_BASE && eff_addr <= GPR_TOP)
            region = RG_GPR;
        else
            region = RG_NONE;   // covers the redirect target 00H as well
    end
endmodule

// File: rtl/dmem_gpr.sv
module dmem_gpr #(
    parameter int DW    = 8,
    parameter int DEPTH = 96,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            mem_d[i] = mem_q[i];
        if (wr && (int'(wr_idx) < DEPTH))
            mem_d[wr_idx] = wr_val;
        rd_val = (int'(rd_idx) < DEPTH) ? mem_q[rd_idx] : '0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++)
            mem_q[i] <= mem_d[i];
    end
endmodule

// File: rtl/dmem_core.sv
module dmem_core
    import dmem_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] IND_ADDR = 8'h00,
    parameter logic [AW-1:0] PTR_ADDR = 8'h01,
    parameter logic [AW-1:0] ACC_ADDR = 8'h05,
    parameter logic [AW-1:0] GPR_BASE = 8'h20,
    parameter logic [AW-1:0] GPR_TOP  = 8'h7F,
    localparam int           DEPTH    = int'(GPR_TOP) - int'(GPR_BASE) + 1,
    localparam int           IW       = $clog2(DEPTH),
    localparam int           BW       = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          bit_en,
    input  logic [BW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DW-1:0] ptr;
        logic [DW-1:0] acc;
    } sfr_t;

    sfr_t          st_q, st_d;
    logic [AW-1:0] eff_addr;
    region_e       region;
    logic [IW-1:0] gpr_idx;
    logic [DW-1:0] gpr_rd;
    logic [DW-1:0] cur_d, new_d;
    logic          store_d, gpr_wr_d;

    dmem_decode #(
        .AW(AW), .IW(IW), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR),
        .ACC_ADDR(ACC_ADDR), .GPR_BASE(GPR_BASE), .GPR_TOP(GPR_TOP)
    ) u_dec (
        .addr(addr), .ptr(st_q.ptr[AW-1:0]), .eff_addr(eff_addr),
        .region(region), .gpr_idx(gpr_idx)
    );

    dmem_gpr #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_gpr (
        .clk(clk), .wr(gpr_wr_d), .wr_idx(gpr_idx), .wr_val(new_d),
        .rd_idx(gpr_idx), .rd_val(gpr_rd)
    );

    always_comb begin
        unique case (region)
            RG_PTR:  cur_d = st_q.ptr;
            RG_ACC:  cur_d = st_q.acc;
            RG_GPR:  cur_d = gpr_rd;
            default: cur_d = '0;
        endcase
        rd_data = cur_d;

        // byte write wins; otherwise read-modify-write of one bit
        new_d = cur_d;
        if (wr_en)
            new_d = wr_data;
        else
            new_d[bit_idx] = bit_val;

        store_d  = (wr_en || bit_en) && !rst;
        gpr_wr_d = store_d && (region == RG_GPR);

        st_d = st_q;
        if (store_d && region == RG_PTR) st_d.ptr = new_d;
        if (store_d && region == RG_ACC) st_d.acc = new_d;
        if (rst) begin
            st_d.ptr = '0;
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    p_ptr_zero_read_r5: assert property (@(posedge clk) disable iff (rst)
        (addr == IND_ADDR && st_q.ptr == '0) |-> rd_data == '0);

    p_ptr_zero_write_r6: assert property (@(posedge clk) disable iff (rst)
        (addr == IND_ADDR && st_q.ptr == '0 && (wr_en || bit_en))
        |=> ($stable(st_q.ptr) && $stable(st_q.acc)));

    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (addr != IND_ADDR && addr != PTR_ADDR && addr != ACC_ADDR &&
         (addr < GPR_BASE || addr > GPR_TOP)) |-> rd_data == '0);

    p_acc_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ACC_ADDR) |=> st_q.acc == $past(wr_data));

    p_acc_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !wr_en && addr == ACC_ADDR)
        |=> st_q.acc[$past(bit_idx)] == $past(bit_val));

    p_reset_clear_r11: assert property (@(posedge clk)
        $past(rst) |-> (st_q.ptr == '0 && st_q.acc == '0));
endmodule

// File: tb/sim_dmem_core.sv
module sim_dmem_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_en = 1'b0;
    logic [2:0] bit_idx = '0;
    logic       bit_val = 1'b0;
    logic [7:0] rd_data;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dmem_core u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val), .rd_data(rd_data)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bop(input logic [7:0] a, input logic [2:0] i, input logic v);
        @(negedge clk);
        addr = a; bit_idx = i; bit_val = v; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s addr %02h: got %02h expected %02h", req, a, rd_data, exp);
        end
    endtask

    task automatic t_reset;
        wr(8'h05, 8'h5A);
        wr(8'h01, 8'h33);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(8'h01, 8'h00, "R11");
        chk(8'h05, 8'h00, "R11");
    endtask

    task automatic t_gpr;
        wr(8'h20, 8'hA5);
        wr(8'h7F, 8'h3C);
        wr(8'h50, 8'h0F);
        chk(8'h20, 8'hA5, "R1");
        chk(8'h7F, 8'h3C, "R1");
        chk(8'h50, 8'h0F, "R1");
    endtask

    task automatic t_sfr;
        wr(8'h01, 8'h21);
        chk(8'h01, 8'h21, "R2");
        wr(8'h05, 8'h77);
        chk(8'h05, 8'h77, "R3");
    endtask

    task automatic t_indirect;
        wr(8'h01, 8'h30);
        wr(8'h00, 8'h99);
        chk(8'h30, 8'h99, "R4");
        wr(8'h30, 8'h44);
        chk(8'h00, 8'h44, "R4");
        wr(8'h01, 8'h05);
        wr(8'h00, 8'h12);
        chk(8'h05, 8'h12, "R4");
        wr(8'h01, 8'h01);
        chk(8'h00, 8'h01, "R4");
    endtask

    task automatic t_ptr_zero;
        wr(8'h05, 8'hAB);
        wr(8'h20, 8'hC3);
        wr(8'h01, 8'h00);
        chk(8'h00, 8'h00, "R5");
        wr(8'h00, 8'h55);
        chk(8'h05, 8'hAB, "R6");
        chk(8'h01, 8'h00, "R6");
        chk(8'h20, 8'hC3, "R6");
    endtask

    task automatic t_reserved;
        wr(8'h03, 8'hFF);
        chk(8'h03, 8'h00, "R7");
        chk(8'h1F, 8'h00, "R7");
        wr(8'h80, 8'hFF);
        chk(8'h80, 8'h00, "R7");
        chk(8'hFF, 8'h00, "R7");
        chk(8'h05, 8'hAB, "R7");
    endtask

    task automatic t_bit;
        wr(8'h05, 8'h00);
        bop(8'h05, 3'd7, 1'b1);
        chk(8'h05, 8'h80, "R8");
        bop(8'h05, 3'd0, 1'b1);
        chk(8'h05, 8'h81, "R8");
        bop(8'h05, 3'd7, 1'b0);
        chk(8'h05, 8'h01, "R8");
        wr(8'h40, 8'hFF);
        bop(8'h40, 3'd3, 1'b0);
        chk(8'h40, 8'hF7, "R8");
    endtask

    task automatic t_bit_ind;
        wr(8'h01, 8'h40);
        bop(8'h00, 3'd0, 1'b0);
        chk(8'h40, 8'hF6, "R9");
        wr(8'h01, 8'h00);
        bop(8'h00, 3'd1, 1'b1);
        chk(8'h05, 8'h01, "R9");
        chk(8'h01, 8'h00, "R9");
    endtask

    task automatic t_prio;
        @(negedge clk);
        addr = 8'h05; wr_data = 8'h10; wr_en = 1'b1;
        bit_idx = 3'd0; bit_val = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bit_en = 1'b0;
        chk(8'h05, 8'h10, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gpr();
        t_sfr();
        t_indirect();
        t_ptr_zero();
        t_reserved();
        t_bit();
        t_bit_ind();
        t_prio();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule